// File: doc/BRIEF.md
# SMBus Slave Register Interface

This block is a byte-oriented serial-bus slave that lets a bus master reach a small bank of 8-bit registers elsewhere on the chip. Both bus lines are oversampled by the system clock through two-flop synchronizers and edge-detected. The clock line is input-only. The data line is open-drain: the block only asserts a drive-low enable, and the resolved bus level comes back on a separate input. No clock stretching is done, so the system clock must run at least eight times faster than the bus clock.

The 7-bit slave address is a fixed five-bit prefix followed by two strap bits. The strap bits arrive already resolved and are captured only while reset is asserted. Every write transfer first loads an internal register pointer. Each later byte in that transfer writes the register the pointer selects, and the pointer then advances. A read transfer returns bytes starting at the current pointer and also advances the pointer after each byte. The register bank hangs off a simple port made of an address, write data, a write strobe and combinational read data. A configurable address window is read-only: writes into it are acknowledged on the bus but never reach the register port.

Top module: `smb_reg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 01011 followed by the captured strap bits {A1,A0}. A grounded strap is 00, an open strap is 10 (address 0x2E), and a strap tied high is 01. The low bit of that byte selects the direction: 0 means the master writes and 1 means the master reads.
- R2: The strap bits are captured while reset is low. Changes after reset leaves have no effect on the address until the next reset.
- R3: A START (data falls while clock is high) begins a new address phase from any state, including inside a transfer. A STOP (data rises while clock is high) returns the block to idle with the data line released. After reset the data line is released and no register write is issued.
- R4: On a matching address the block pulls the data line low for the whole ninth clock. On a mismatch it drives nothing, and acknowledges no further byte, until the next START.
- R5: The first data byte of a write transfer is loaded into the pointer, is acknowledged, and causes no register write.
- R6: Each later write byte is acknowledged and written to the register at the pointer, after which the pointer advances by one.
- R7: A read transfer sends, MSB first, the register at the current pointer. After each byte the pointer advances by one, and a master ACK makes the next register follow.
- R8: When the master answers a read byte with NACK, the block leaves the data line released and returns to idle.
- R9: The drive-low enable changes only while the bus clock is low.
- R10: Write bytes aimed at the read-only window (0x0C to 0x0F by default) are acknowledged and discarded, and the pointer still advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rstN | input | 1 | Active-low asynchronous reset; strap is captured while low |
| strapBits | input | 2 | Resolved strap bits {A1,A0} forming the address low bits |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Resolved bus data level |
| sdaDrvLow | output | 1 | When high, the data line is pulled low |
| regAddr | output | 8 | Register port address (current pointer) |
| regWrData | output | 8 | Register port write data |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdData | input | 8 | Register port read data for regAddr |

## Verification
Address bytes are tried both matching and mismatching by one bit in the prefix, in each strap bit and in the direction position. A byte sent after a mismatch shows whether the block really stays quiet. Strap changes are applied with and without a reset between them, which separates a live strap path from a latched one. Write transfers carrying only a pointer, several data bytes, or bytes that cross into the read-only window distinguish pointer loading, auto-increment and write suppression. Reads ended by ACK versus NACK, and a repeated START that turns a pointer write into a read, show that data order, pointer continuation and line release are correct.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ
  } smbState_t;

  // Events decoded by the datapath, consumed by the control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
    logic addrMatch;
    logic rwBit;
  } smbEvent_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ptrLoad;
    logic ptrInc;
    logic regWrite;
    logic sdaAck;
    logic sdaRelease;
  } smbStrobe_t;

endpackage

// File: rtl/smb_dp.sv
module smb_dp
  import smb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PREFIX_W    = 5,
  parameter int unsigned STRAP_W     = 2,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b01011,
  parameter int unsigned RO_LO       = 12,
  parameter int unsigned RO_HI       = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapBits,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  smbStrobe_t         strb,
  output smbEvent_t          ev,
  output logic               sdaDrvLow,
  output logic [DATA_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regWrData,
  output logic               regWrEn,
  input  logic [DATA_W-1:0]  regRdData
);

  localparam int unsigned SLV_W = PREFIX_W + STRAP_W;
  localparam logic [DATA_W-1:0] RO_LO_V = DATA_W'(RO_LO);
  localparam logic [DATA_W-1:0] RO_HI_V = DATA_W'(RO_HI);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclS, sdaS, sclD, sdaD;
  logic [STRAP_W-1:0]     strapQ;
  logic [DATA_W-1:0]      rxSh;
  logic [DATA_W-1:0]      txSh;
  logic [DATA_W-1:0]      ptr;
  logic                   ptrIsRo;

  // Bus line synchronizers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // Strap bits follow the input only while reset is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strapQ <= strapBits;
    else       strapQ <= strapQ;
  end

  always_comb begin
    ev.sclRise   = sclS & ~sclD;
    ev.sclFall   = ~sclS & sclD;
    ev.startDet  = sclS & sclD & sdaD & ~sdaS;
    ev.stopDet   = sclS & sclD & ~sdaD & sdaS;
    ev.sdaBit    = sdaS;
    ev.addrMatch = (rxSh[DATA_W-1 -: SLV_W] == {ADDR_PREFIX, strapQ});
    ev.rwBit     = rxSh[0];
  end

  // Receive and transmit shifters, pointer, open-drain drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      txSh      <= '0;
      ptr       <= '0;
      sdaDrvLow <= 1'b0;
    end else begin
      if (strb.rxShift) rxSh <= {rxSh[DATA_W-2:0], sdaS};

      if (strb.txLoad)       txSh <= regRdData;
      else if (strb.txShift) txSh <= {txSh[DATA_W-2:0], 1'b0};

      if (strb.ptrLoad)     ptr <= rxSh;
      else if (strb.ptrInc) ptr <= ptr + 1'b1;

      if (strb.sdaRelease)   sdaDrvLow <= 1'b0;
      else if (strb.sdaAck)  sdaDrvLow <= 1'b1;
      else if (strb.txLoad)  sdaDrvLow <= ~regRdData[DATA_W-1];
      else if (strb.txShift) sdaDrvLow <= ~txSh[DATA_W-2];
    end
  end

  assign ptrIsRo   = (ptr >= RO_LO_V) && (ptr <= RO_HI_V);
  assign regAddr   = ptr;
  assign regWrData = rxSh;
  assign regWrEn   = strb.regWrite & ~ptrIsRo;

  // R9: drive changes only as a result of a clock-low cycle
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDrvLow) && !$past(ev.startDet) && !$past(ev.stopDet)) |-> !$past(sclS));

  // R3: a STOP always leaves the line released
  a_r3_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !sdaDrvLow);

  // R2: captured strap never moves outside reset
  a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rstN)
    ev.sclRise |=> $stable(strapQ));

  // R5: pointer takes the received byte
  a_r5_ptr_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrLoad |=> (ptr == $past(rxSh)));

  // R6: pointer advances by exactly one
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && !strb.ptrLoad) |=> (ptr == DATA_W'($past(ptr) + 1'b1)));

  // R7: first transmitted bit is the register MSB
  a_r7_msb_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txLoad && !strb.sdaRelease) |=> (sdaDrvLow == !$past(regRdData[DATA_W-1])));

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  smbEvent_t  ev,
  output smbStrobe_t strb
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  smbState_t        state, stateN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic             ackPhase, ackN;
  logic             firstByte, firstN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      firstByte <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= cntN;
      ackPhase  <= ackN;
      firstByte <= firstN;
    end
  end

  always_comb begin
    stateN = state;
    cntN   = bitCnt;
    ackN   = ackPhase;
    firstN = firstByte;
    strb   = '0;
    if (ev.startDet) begin
      stateN          = ST_ADDR;
      cntN            = '0;
      ackN            = 1'b0;
      strb.sdaRelease = 1'b1;
    end else if (ev.stopDet) begin
      stateN          = ST_IDLE;
      ackN            = 1'b0;
      strb.sdaRelease = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_WRITE: begin
          if (!ackPhase) begin
            if (ev.sclRise && bitCnt != LAST) begin
              strb.rxShift = 1'b1;
              cntN         = bitCnt + 1'b1;
            end else if (ev.sclFall && bitCnt == LAST) begin
              if (state == ST_WRITE) begin
                strb.sdaAck = 1'b1;
                ackN        = 1'b1;
                if (firstByte) begin
                  strb.ptrLoad = 1'b1;
                  firstN       = 1'b0;
                end else begin
                  strb.regWrite = 1'b1;
                  strb.ptrInc   = 1'b1;
                end
              end else if (ev.addrMatch) begin
                strb.sdaAck = 1'b1;
                ackN        = 1'b1;
              end else begin
                strb.sdaRelease = 1'b1;
                stateN          = ST_IDLE;
              end
            end
          end else if (ev.sclFall) begin
            ackN = 1'b0;
            cntN = '0;
            if (state == ST_ADDR && ev.rwBit) begin
              stateN      = ST_READ;
              strb.txLoad = 1'b1;
            end else begin
              strb.sdaRelease = 1'b1;
              if (state == ST_ADDR) begin
                stateN = ST_WRITE;
                firstN = 1'b1;
              end
            end
          end
        end
        ST_READ: begin
          if (!ackPhase) begin
            if (ev.sclRise && bitCnt != LAST) begin
              cntN = bitCnt + 1'b1;
            end else if (ev.sclFall) begin
              if (bitCnt == LAST) begin
                strb.sdaRelease = 1'b1;
                strb.ptrInc     = 1'b1;
                ackN            = 1'b1;
              end else if (bitCnt != '0) begin
                strb.txShift = 1'b1;
              end
            end
          end else begin
            if (ev.sclRise && ev.sdaBit) begin
              stateN = ST_IDLE;
              ackN   = 1'b0;
            end else if (ev.sclFall) begin
              strb.txLoad = 1'b1;
              cntN        = '0;
              ackN        = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R4: leaving idle is only ever caused by a START
  a_r4_idle_exit_start: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) == ST_IDLE) |-> $past(ev.startDet));

  // R1: an address acknowledge requires a matching address
  a_r1_ack_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sdaAck && state == ST_ADDR) |-> ev.addrMatch);

  // R8: master NACK on a read byte ends the transfer
  a_r8_nack_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && ackPhase && ev.sclRise && ev.sdaBit
     && !ev.startDet && !ev.stopDet) |=> (state == ST_IDLE));

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PREFIX_W    = 5,
  parameter int unsigned STRAP_W     = 2,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b01011,
  parameter int unsigned RO_LO       = 12,
  parameter int unsigned RO_HI       = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapBits,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDrvLow,
  output logic [DATA_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regWrData,
  output logic               regWrEn,
  input  logic [DATA_W-1:0]  regRdData
);

  smbEvent_t  ev;
  smbStrobe_t strb;

  smb_dp #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES),
    .PREFIX_W    (PREFIX_W),
    .STRAP_W     (STRAP_W),
    .ADDR_PREFIX (ADDR_PREFIX),
    .RO_LO       (RO_LO),
    .RO_HI       (RO_HI)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strapBits (strapBits),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strb      (strb),
    .ev        (ev),
    .sdaDrvLow (sdaDrvLow),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .regRdData (regRdData)
  );

  smb_ctrl #(
    .DATA_W (DATA_W)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .ev   (ev),
    .strb (strb)
  );

endmodule

// File: tb/tb_smb_reg_slave.sv
`timescale 1ns/1ps
module tb_smb_reg_slave;

  localparam int Q = 6;
  localparam logic [7:0] ADDR_VEC [8] = '{
    {7'h2E, 1'b1}, {7'h2F, 1'b0}, {7'h2C, 1'b0}, {7'h2D, 1'b0},
    {7'h6E, 1'b0}, {7'h0E, 1'b0}, {7'h2A, 1'b0}, {7'h3E, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] strap = 2'b10;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaBus;
  logic       sdaDrvLow;
  logic [7:0] regAddr, regWrData, regRdData;
  logic       regWrEn;
  logic [7:0] regs [16];
  int         wrCount = 0;
  int         compared = 0;
  int         mismatched = 0;
  int         viol = 0;
  logic       prevScl = 1'b1;
  logic       prevDrv = 1'b0;
  logic       finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaDrvLow;
  assign regRdData = regs[regAddr[3:0]];

  smb_reg_slave dut (
    .clk       (clk),
    .rstN      (rstN),
    .strapBits (strap),
    .sclIn     (sclM),
    .sdaIn     (sdaBus),
    .sdaDrvLow (sdaDrvLow),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .regRdData (regRdData)
  );

  // Register bank model on the far side of the port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'hA0 + 8'(i);
    end else if (regWrEn) begin
      regs[regAddr[3:0]] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  // R9 monitor: drive must not move while the bus clock stays high
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaDrvLow != prevDrv)) viol++;
    prevScl <= sclM;
    prevDrv <= sdaDrvLow;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b0; qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b1; qwait();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    qwait();
    sclM = 1'b1; qwait(); qwait();
    sclM = 1'b0; qwait();
  endtask

  // Samples twice while clock is high; low only if low at both points
  task automatic recvBit(output logic b);
    logic s1;
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    s1 = sdaBus; qwait();
    b = s1 | sdaBus;
    sclM = 1'b0; qwait();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic ackIt);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(~ackIt);
  endtask

  task automatic setPtr(input logic [6:0] slv, input logic [7:0] p);
    logic a;
    busStart();
    sendByte({slv, 1'b0}, a);
    sendByte(p, a);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         w0;

    doReset();
    // R3: reset state
    chk("R3 reset drive", sdaDrvLow, 0);
    chk("R3 reset write strobe", regWrEn, 0);

    // R1 / R4: address table walk, strap open (10)
    for (int v = 0; v < 8; v++) begin
      busStart();
      sendByte({ADDR_VEC[v][7:1], 1'b0}, ack);
      chk("R1 address ack", ack, ADDR_VEC[v][0]);
      if (!ADDR_VEC[v][0]) begin
        sendByte(8'h00, ack);
        chk("R4 quiet after mismatch", ack, 0);
      end
      busStop();
      chk("R3 released after stop", sdaDrvLow, 0);
    end

    // R5: pointer-only write, then read at that pointer (R7)
    w0 = wrCount;
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    chk("R4 ack on match", ack, 1);
    sendByte(8'h03, ack);
    chk("R5 pointer byte ack", ack, 1);
    busStop();
    chk("R5 no register write", wrCount - w0, 0);
    busStart();
    sendByte({7'h2E, 1'b1}, ack);
    recvByte(d, 1'b0);
    chk("R7 read at pointer", d, 8'hA3);
    chk("R8 released after nack", sdaDrvLow, 0);
    busStop();

    // R6: multi-byte write
    w0 = wrCount;
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    sendByte(8'h04, ack);
    sendByte(8'h11, ack); chk("R6 data ack", ack, 1);
    sendByte(8'h22, ack); chk("R6 data ack", ack, 1);
    sendByte(8'h33, ack); chk("R6 data ack", ack, 1);
    busStop();
    chk("R6 write count", wrCount - w0, 3);
    chk("R6 reg4", regs[4], 8'h11);
    chk("R6 reg5", regs[5], 8'h22);
    chk("R6 reg6", regs[6], 8'h33);

    // R7: multi-byte read, then continuation
    setPtr(7'h2E, 8'h04);
    busStart();
    sendByte({7'h2E, 1'b1}, ack);
    recvByte(d, 1'b1); chk("R7 byte0", d, 8'h11);
    recvByte(d, 1'b1); chk("R7 byte1", d, 8'h22);
    recvByte(d, 1'b0); chk("R7 byte2", d, 8'h33);
    chk("R8 released after nack", sdaDrvLow, 0);
    busStop();
    busStart();
    sendByte({7'h2E, 1'b1}, ack);
    recvByte(d, 1'b0);
    chk("R7 pointer continues", d, 8'hA7);
    busStop();

    // R10: write running into the read-only window
    w0 = wrCount;
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    sendByte(8'h0B, ack);
    sendByte(8'h66, ack); chk("R10 writable ack", ack, 1);
    sendByte(8'h77, ack); chk("R10 read-only ack", ack, 1);
    busStop();
    chk("R10 one write issued", wrCount - w0, 1);
    setPtr(7'h2E, 8'h0B);
    busStart();
    sendByte({7'h2E, 1'b1}, ack);
    recvByte(d, 1'b1); chk("R10 reg 0x0B", d, 8'h66);
    recvByte(d, 1'b0); chk("R10 reg 0x0C kept", d, 8'hAC);
    busStop();

    // R3: repeated START turns pointer write into read
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    sendByte(8'h09, ack);
    busStart();
    sendByte({7'h2E, 1'b1}, ack);
    chk("R3 repeated start ack", ack, 1);
    recvByte(d, 1'b0);
    chk("R3 repeated start read", d, 8'hA9);
    busStop();

    // R2: strap change without reset has no effect
    strap = 2'b01;
    repeat (10) @(negedge clk);
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    busStop();
    chk("R2 old address kept", ack, 1);
    busStart();
    sendByte({7'h2D, 1'b0}, ack);
    busStop();
    chk("R2 new address ignored", ack, 0);

    // R1: strap tied high (01) and grounded (00) after reset
    doReset();
    busStart();
    sendByte({7'h2D, 1'b0}, ack);
    busStop();
    chk("R1 strap high address", ack, 1);
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    busStop();
    chk("R1 open address rejected", ack, 0);
    strap = 2'b00;
    doReset();
    busStart();
    sendByte({7'h2C, 1'b0}, ack);
    busStop();
    chk("R1 strap ground address", ack, 1);

    chk("R9 drive moved with clock high", viol, 0);
    summary();
  end

endmodule